// File: doc/BRIEF.md
# Twisted-Ring Decade Counter with One-Hot Decode

This block counts through ten states held in a five-stage twisted-ring (Johnson) register. It turns the current state into ten one-hot lines and a carry. Exactly one line is high in each decimal period. Every line is formed from a pair of neighbouring stages, so only one stage changes per step and the decode has no intermediate codes. The carry stays high for the first half of the decade and falls for the second half. Its rising edge therefore marks each wrap from nine to zero, and a following stage can count on it.

The block runs on a single system clock. The count source (`cnt_clk_i`) and the inhibit input (`inhibit_i`) are sampled on that clock. A step happens in either of two cases:
- a rising transition of `cnt_clk_i` while inhibit is low;
- a falling transition of inhibit while `cnt_clk_i` is high, so inhibit also works as a falling-edge count source.

A synchronous clear forces state zero and overrides any step. Tying one decoded line back to the clear input shortens the cycle, which divides by N. The lines and the carry are registered and change in the same system-clock cycle as the ring. The block has no data stream, so there is no valid/ready handshake and no back-pressure: every pin is a plain level.

Top module: `jdc_top`

## Requirements
- R1: While `rst_n` is low at a rising system-clock edge, the ring returns to state zero. In the cycle after that edge, `dec_o` is 10'b0000000001 and `carry_o` is 1.
- R2: Exactly one bit of `dec_o` is high in every cycle out of reset. Bit k is high during count k.
- R3: A system-clock edge at which `cnt_clk_i` is 1, its previous sample was 0, and `inhibit_i` is 0 advances the count by one. `dec_o` rotates one place toward the MSB, bit 9 wraps to bit 0, and the new value is visible after that same edge.
- R4: While `inhibit_i` is 1, rising transitions of `cnt_clk_i` leave `dec_o` and `carry_o` unchanged.
- R5: An edge at which `cnt_clk_i` is 1 in this sample and the previous one, and `inhibit_i` is 0 after a previous sample of 1, advances the count by one.
- R6: `clear_i` high at an edge forces count zero in the next cycle, even when a step condition is present at the same edge.
- R7: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises on the 9 to 0 wrap.
- R8: When `cnt_clk_i` rises and `inhibit_i` falls at the same sample, the count advances exactly once.
- R9: Steady inputs, a falling `cnt_clk_i`, or a rising `inhibit_i` cause no step.
- R10: Feeding `dec_o[n]` back into `clear_i` makes the count cycle 0 to n-1. Line n is high for only one system-clock cycle before the clear takes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_clk_i | input | 1 | Count source; its sampled rising transition steps the count |
| inhibit_i | input | 1 | High blocks count-source steps; its falling transition while the count source is high steps the count |
| clear_i | input | 1 | Synchronous clear to count zero, highest priority |
| dec_o | output | 10 | One-hot decoded count, bit k high for count k |
| carry_o | output | 1 | High for counts 0 to 4, low for 5 to 9 |

## Verification
The clear and a step can fall in the same system-clock cycle. The bench provokes this by raising `clear_i` on the same sample as a rising count source, and again in divide-by-N mode, where the decoded line drives the clear. The bench judges the result at the ports: the cycle after the edge must show line 0 and a high carry, not the next count. A second collision, a count-source rise together with an inhibit fall, must produce one step and not two.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_RISE = 2'd1,
    ADV_FALL = 2'd2,
    ADV_BOTH = 2'd3
  } adv_kind_e;
endpackage

// File: rtl/jdc_edge_detect.sv
module jdc_edge_detect
  import jdc_pkg::*;
(
  input  logic      clk,
  input  logic      cnt_clk_i,
  input  logic      inhibit_i,
  output adv_kind_e kind_o
);
  logic clk_smp_q;
  logic inh_smp_q;

  // samples follow the pins in every cycle, reset included, so no false edge after reset
  always_ff @(posedge clk) begin
    clk_smp_q <= cnt_clk_i;
    inh_smp_q <= inhibit_i;
  end

  logic rise_hit;
  logic fall_hit;

  always_comb begin
    rise_hit = cnt_clk_i & ~clk_smp_q & ~inhibit_i;
    fall_hit = inh_smp_q & ~inhibit_i & cnt_clk_i;
    unique case ({fall_hit, rise_hit})
      2'b01:   kind_o = ADV_RISE;
      2'b10:   kind_o = ADV_FALL;
      2'b11:   kind_o = ADV_BOTH;
      default: kind_o = ADV_NONE;
    endcase
  end
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int STAGES = 5,
  localparam int LINES = 2 * STAGES
) (
  input  logic [STAGES-1:0] state_i,
  output logic [LINES-1:0]  lines_o,
  output logic              carry_o,
  output logic              legal_o
);
  localparam int FULL = (1 << STAGES) - 1;

  logic [LINES-1:0] hit;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == 0) begin : g_zero
      assign lines_o[i] = ~state_i[STAGES-1] & ~state_i[0];
    end else if (i < STAGES) begin : g_fill
      assign lines_o[i] = state_i[i-1] & ~state_i[i];
    end else if (i == STAGES) begin : g_full
      assign lines_o[i] = state_i[STAGES-1] & state_i[0];
    end else begin : g_drain
      assign lines_o[i] = state_i[i-STAGES] & ~state_i[i-STAGES-1];
    end

    localparam int CODE_INT = (i <= STAGES) ? ((1 << i) - 1)
                                            : ((FULL << (i - STAGES)) & FULL);
    localparam logic [STAGES-1:0] CODE = CODE_INT[STAGES-1:0];
    assign hit[i] = (state_i == CODE);
  end

  assign carry_o = ~state_i[STAGES-1];
  assign legal_o = |hit;
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  adv_kind_e         kind_i,
  input  logic              legal_i,
  output logic [STAGES-1:0] state_q,
  output logic [STAGES-1:0] state_d
);
  always_comb begin
    if (!rst_n || clear_i) begin
      state_d = '0;
    end else if (kind_i != ADV_NONE) begin
      // an illegal pattern is folded back to zero on the next step
      state_d = legal_i ? {state_q[STAGES-2:0], ~state_q[STAGES-1]} : '0;
    end else begin
      state_d = state_q;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/jdc_top.sv
module jdc_top
  import jdc_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int LINES = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             clear_i,
  output logic [LINES-1:0] dec_o,
  output logic             carry_o
);
  adv_kind_e         kind;
  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic [LINES-1:0]  lines_cur;
  logic              carry_cur;
  logic              legal_cur;
  logic [LINES-1:0]  lines_nxt;
  logic              carry_nxt;
  logic              legal_nxt;

  jdc_edge_detect u_edge (
    .clk       (clk),
    .cnt_clk_i (cnt_clk_i),
    .inhibit_i (inhibit_i),
    .kind_o    (kind)
  );

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .kind_i  (kind),
    .legal_i (legal_cur),
    .state_q (state_q),
    .state_d (state_d)
  );

  // decode of the present state judges legality
  jdc_decode #(.STAGES(STAGES)) u_dec_cur (
    .state_i (state_q),
    .lines_o (lines_cur),
    .carry_o (carry_cur),
    .legal_o (legal_cur)
  );

  // decode of the next state feeds the output registers
  jdc_decode #(.STAGES(STAGES)) u_dec_nxt (
    .state_i (state_d),
    .lines_o (lines_nxt),
    .carry_o (carry_nxt),
    .legal_o (legal_nxt)
  );

  logic unused_ok;
  assign unused_ok = ^{lines_cur, carry_cur, legal_nxt};

  always_ff @(posedge clk) begin
    dec_o   <= lines_nxt;
    carry_o <= carry_nxt;
  end
endmodule

// File: rtl/jdc_top_checker.sv
module jdc_top_checker #(
  parameter int LINES = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clk_i,
  input logic             inhibit_i,
  input logic             clear_i,
  input logic [LINES-1:0] dec_o,
  input logic             carry_o
);
  localparam int HALF = LINES / 2;

  logic rst_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b1;
    else if (rst_seen !== 1'b1) rst_seen <= 1'b0;
  end

  logic live;
  assign live = rst_n && (rst_seen === 1'b1);

  a_r2_one_hot: assert property (@(posedge clk) disable iff (!live)
    $countones(dec_o) == 1);

  a_r7_carry_half: assert property (@(posedge clk) disable iff (!live)
    carry_o == (|dec_o[HALF-1:0]));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!live)
    clear_i |=> dec_o[0]);

  a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (!live)
    (inhibit_i && $past(inhibit_i) && !clear_i) |=> $stable(dec_o));

  a_r3_rise_step: assert property (@(posedge clk) disable iff (!live)
    (cnt_clk_i && !$past(cnt_clk_i) && !inhibit_i && !clear_i)
      |=> dec_o == {$past(dec_o[LINES-2:0]), $past(dec_o[LINES-1])});

  a_r5_fall_step: assert property (@(posedge clk) disable iff (!live)
    (cnt_clk_i && $past(cnt_clk_i) && !inhibit_i && $past(inhibit_i) && !clear_i)
      |=> dec_o == {$past(dec_o[LINES-2:0]), $past(dec_o[LINES-1])});
endmodule

bind jdc_top jdc_top_checker #(.LINES(LINES)) u_jdc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_clk_i (cnt_clk_i),
  .inhibit_i (inhibit_i),
  .clear_i   (clear_i),
  .dec_o     (dec_o),
  .carry_o   (carry_o)
);

// File: tb/jdc_top_tb_top.sv
module jdc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_clk = 1'b0;
  logic       inhibit = 1'b0;
  logic       clear_drv = 1'b0;
  logic       div_en = 1'b0;
  logic       clear_w;
  logic [9:0] dec;
  logic       carry;
  int         n_chk = 0;
  int         n_fail = 0;
  int         model = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign clear_w = clear_drv | (div_en & dec[3]);

  jdc_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clk_i (cnt_clk),
    .inhibit_i (inhibit),
    .clear_i   (clear_w),
    .dec_o     (dec),
    .carry_o   (carry)
  );

  task automatic check(input string req);
    logic [9:0] ed;
    logic       ec;
    ed = 10'b1 << model;
    ec = (model < 5);
    n_chk++;
    if (dec !== ed || carry !== ec) begin
      n_fail++;
      $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b", req, dec, carry, ed, ec);
    end
  endtask

  task automatic step_model();
    model = (model + 1) % 10;
  endtask

  task automatic pulse();
    cnt_clk = 1'b1;
    @(negedge clk);
    cnt_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model = 0;
    check("R1 reset");
  endtask

  task automatic t_count();
    for (int i = 0; i < 12; i++) begin
      pulse();
      step_model();
      check(model == 0 ? "R7 wrap carry" : "R3/R2 step");
    end
    repeat (4) @(negedge clk);
    check("R9 steady");
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1;
    @(negedge clk);
    check("R9 inhibit rise");
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R4 inhibited rise");
    end
    cnt_clk = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 high under inhibit");
    inhibit = 1'b0;
    @(negedge clk);
    step_model();
    check("R5 inhibit fall");
    repeat (2) @(negedge clk);
    check("R9 hold after fall");
    cnt_clk = 1'b0;
    @(negedge clk);
    check("R9 clk fall");
    cnt_clk = 1'b1;
    @(negedge clk);
    step_model();
    inhibit = 1'b1;
    @(negedge clk);
    check("R9 inhibit rise with clk high");
    cnt_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_both();
    cnt_clk = 1'b0;
    inhibit = 1'b1;
    repeat (2) @(negedge clk);
    cnt_clk = 1'b1;
    inhibit = 1'b0;
    @(negedge clk);
    step_model();
    check("R8 joint edge one step");
    repeat (2) @(negedge clk);
    check("R8 no second step");
    cnt_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_clear();
    pulse();
    step_model();
    pulse();
    step_model();
    check("R3 before clear");
    clear_drv = 1'b1;
    cnt_clk = 1'b1;
    @(negedge clk);
    clear_drv = 1'b0;
    model = 0;
    check("R6 clear beats step");
    cnt_clk = 1'b0;
    @(negedge clk);
    check("R6 held zero");
  endtask

  task automatic t_divide();
    div_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      cnt_clk = 1'b1;
      @(negedge clk);
      cnt_clk = 1'b0;
      model = model + 1;
      if (model == 3) begin
        check("R10 line n briefly");
        model = 0;
      end
      @(negedge clk);
      check("R10 divide by 3");
    end
    div_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_count();
    t_inhibit();
    t_both();
    t_clear();
    t_divide();
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule